// File: doc/BRIEF.md
# External Reset Pulse Shaper

This block drives the active-low reset line that a chip shares with the external devices on its board. A reset sequencer inside the chip raises a one-cycle request. The shaper then pulls the pin drive low for a fixed number of slow-clock cycles, so that every device on the shared line sees a reset long enough to take effect. It then releases the line.

The pulse length is a power of two. A 4-bit length code `len` gives 2^(len+1) slow-clock cycles, so the pulse runs from 2 cycles up to 65536 cycles. With a clock near 32 kHz that is roughly 60 µs to 2 s. The code is captured when the pulse starts. A busy flag stays high for the whole low interval, so the sequencer can wait for it to fall. The output is a registered drive level, where 0 means pull the pad low and 1 means release it.

Top module: `ext_rst_shaper`

## Requirements
- R1: While `rst_ni` is low, and after it is released, `rst_drive_no` is 1 (released) and `busy_o` is 0.
- R2: A request that is high at a rising clock edge while the block is idle makes `rst_drive_no` low from that edge onward.
- R3: The low interval lasts exactly 2^(len+1) clock cycles, where `len` is the unsigned value of `len_i` sampled with the request; `len_i` = 0 gives exactly 2 cycles.
- R4: `len_i` = 15 gives exactly 65536 low cycles.
- R5: Changes to `len_i` during a pulse leave that pulse's length unchanged.
- R6: A request that arrives while a pulse is running is ignored: the pulse is not extended or restarted, and the line stays released after it ends.
- R7: `busy_o` is high in exactly the cycles in which `rst_drive_no` is low.
- R8: If the request is held high across the end of a pulse, the line is released for exactly one cycle and then a new full-length pulse begins.
- R9: Asserting `rst_ni` in the middle of a pulse releases the line and clears busy at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Slow clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| req_i | input | 1 | External-reset request from the reset sequencer |
| len_i | input | 4 | Length code; pulse = 2^(len+1) cycles |
| busy_o | output | 1 | High while the pulse is in progress |
| rst_drive_no | output | 1 | Pin drive level: 0 pulls the line low, 1 releases it |

## Verification
Two events can fall on the same clock edge: the last edge of a pulse, where the counter goes from 1 to 0, and a new request. The bench provokes this by holding the request high continuously across the end of a 2-cycle pulse. It expects the request at the final edge to be ignored, exactly one released cycle to follow, and a second full pulse to start after that. The released gap and the length of both pulses are counted at the pins.

// File: rtl/ext_rst_pkg.sv
package ext_rst_pkg;
  parameter int unsigned LEN_W = 4;
  // largest pulse is 2^(2^LEN_W) cycles; counter must hold that value
  parameter int unsigned CNT_W = (1 << LEN_W) + 1;
  typedef logic [LEN_W-1:0] len_t;
  typedef logic [CNT_W-1:0] cnt_t;
endpackage

// File: rtl/ext_rst_len_decode.sv
module ext_rst_len_decode
  import ext_rst_pkg::*;
(
  input  len_t len_i,
  output cnt_t load_o
);
  localparam cnt_t ONE = cnt_t'(1);

  always_comb begin
    load_o = ONE << (32'(len_i) + 32'd1);
  end
endmodule

// File: rtl/ext_rst_counter.sv
module ext_rst_counter
  import ext_rst_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  cnt_t load_i,
  output cnt_t cnt_o,
  output logic busy_o
);
  cnt_t cnt_q, cnt_d;
  logic busy_q;

  always_comb begin
    cnt_d = cnt_q;
    if (busy_q)       cnt_d = cnt_q - cnt_t'(1);
    else if (req_i)   cnt_d = load_i;
  end

  // busy registered alongside count so the pin level never glitches
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= (cnt_d != '0);
    end
  end

  assign cnt_o  = cnt_q;
  assign busy_o = busy_q;

  // R7
  busy_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q == (cnt_q != '0));

  // R2
  pulse_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && req_i) |=> busy_q);

  // R6
  no_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cnt_q != cnt_t'(1)) |=> (busy_q && cnt_q == $past(cnt_q) - cnt_t'(1)));

  // R8
  release_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cnt_q == cnt_t'(1)) |=> !busy_q);
endmodule

// File: rtl/ext_rst_shaper.sv
module ext_rst_shaper
  import ext_rst_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             busy_o,
  output logic             rst_drive_no
);
  cnt_t load_val;
  cnt_t cnt;
  logic busy;

  ext_rst_len_decode u_dec (
    .len_i  (len_i),
    .load_o (load_val)
  );

  ext_rst_counter u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req_i),
    .load_i (load_val),
    .cnt_o  (cnt),
    .busy_o (busy)
  );

  assign busy_o       = busy;
  assign rst_drive_no = ~busy;

  // R3
  load_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && req_i) |=> (cnt == (cnt_t'(1) << (32'($past(len_i)) + 32'd1))));
endmodule

// File: tb/ext_rst_shaper_tb.sv
module ext_rst_shaper_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic [3:0] len = 4'd0;
  logic busy, drv_n;
  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  localparam int NV = 7;
  localparam int VLEN [NV] = '{0, 1, 2, 3, 5, 8, 15};
  localparam int VEXP [NV] = '{2, 4, 8, 16, 64, 512, 65536};

  always #10 clk = ~clk;

  ext_rst_shaper u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .len_i(len),
    .busy_o(busy), .rst_drive_no(drv_n)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // counts low samples from the current negedge; optional len scrambling / req poking
  task automatic measure(input int exp_n, input bit chg_len, input bit poke,
                         output int n, output bit mism);
    n = 0; mism = 0;
    while (!drv_n && n < 70000) begin
      if (busy !== 1'b1) mism = 1;
      n++;
      if (chg_len) len = ~len;
      if (poke) req = (n < exp_n);
      @(negedge clk);
    end
    if (busy !== 1'b0) mism = 1;
  endtask

  task automatic fire(input int l);
    @(negedge clk);
    req = 1'b1; len = 4'(l);
    @(negedge clk);
    req = 1'b0;
  endtask

  initial begin
    int n, n2; bit mm;
    #5;
    chk(drv_n === 1'b1 && busy === 1'b0, "R1 in reset", {30'b0, busy, drv_n}, 1);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(drv_n === 1'b1 && busy === 1'b0, "R1 after reset", {30'b0, busy, drv_n}, 1);

    for (int i = 0; i < NV; i++) begin
      fire(VLEN[i]);
      chk(drv_n === 1'b0, "R2 low after request", drv_n, 0);
      measure(VEXP[i], 0, 0, n, mm);
      chk(n == VEXP[i], (VLEN[i] == 15) ? "R4 max length" : "R3 length", n, VEXP[i]);
      chk(!mm, "R7 busy tracks drive", mm, 0);
    end

    // R5: length code toggled every cycle of the pulse
    fire(2);
    measure(8, 1, 0, n, mm);
    chk(n == 8, "R5 len change ignored", n, 8);

    // R6: requests throughout the pulse
    fire(3);
    measure(16, 0, 1, n, mm);
    chk(n == 16, "R6 no restart length", n, 16);
    @(negedge clk);
    chk(drv_n === 1'b1, "R6 stays released", drv_n, 1);

    // R8: request held across the end of a pulse
    @(negedge clk);
    req = 1'b1; len = 4'd0;
    @(negedge clk);
    measure(2, 0, 0, n, mm);
    chk(n == 2, "R8 first pulse", n, 2);
    @(negedge clk);
    req = 1'b0;
    chk(drv_n === 1'b0, "R8 one-cycle gap", drv_n, 0);
    measure(2, 0, 0, n2, mm);
    chk(n2 == 2, "R8 second pulse", n2, 2);

    // R9: async reset mid-pulse
    fire(4);
    repeat (3) @(negedge clk);
    #3 rst_n = 1'b0;
    #1;
    chk(drv_n === 1'b1 && busy === 1'b0, "R9 async release", {30'b0, busy, drv_n}, 1);
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(drv_n === 1'b1, "R9 stays released", drv_n, 1);

    done = 1'b1;
  end

  always @(posedge clk) begin
    cycles++;
    if (done || cycles > 150000) begin
      if (!done) chk(0, "watchdog", cycles, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule